// File: doc/BRIEF.md
# Indirect Address Generator

This block turns a 24-bit single-address instruction word into the final 14-bit operand address. Bits are numbered from 0 at the most significant end. If the word's index flag is set, the block adds the index register to the address field. If the word's indirect flag is set, it then reads the memory word at that address and decodes it again as an instruction. Its operation code is ignored, but its own index and indirect flags apply. The chain repeats until a word arrives with no indirect flag. The result is then presented with a one-cycle done strobe.

The block talks to memory through a simple read port. It raises a one-cycle request with an address and waits for a valid strobe with the returned word. There is one read per indirection level. A level counter shows how many reads the current chain has taken. A configurable limit stops a chain that never ends: when the limit is reached, the block raises an error strobe instead of done.

Top module: `ind_addr_gen`

## Requirements
- R1: Field positions in a word, with bit 0 as the MSB (vector bit 23): the index flag is bit 1 (vector bit 22), the indirect flag is bit 9 (vector bit 14), and the address is bits 10-23 (vector bits 13:0). The opcode bits 3-8 (vector 20:15), bit 0 and bit 2 do not affect the result.
- R2: When the index flag is set, the index register is added to the address field modulo 2^14. When it is clear, the address field is used as it is.
- R3: A word without the indirect flag completes with no memory read. `done_o` is high in the second cycle after `start_i` is sampled, and `addr_o` holds the address.
- R4: Each indirection level issues exactly one `rd_req_o` pulse, one cycle wide, with `rd_addr_o` equal to the current indexed address. Indexing happens before the read.
- R5: The returned word is decoded as a full instruction. Its own index and indirect flags apply and its opcode is ignored, so chains can have any number of levels. With a one-cycle memory, each level adds 3 cycles.
- R6: `level_o` is cleared when a new operation starts and rises by one with each read request.
- R7: If a word requests indirection when MAX_LEVELS reads have already been made (default 64), `err_o` pulses instead of `done_o`, and `level_o` equals MAX_LEVELS.
- R8: `start_i` is ignored while an operation is in progress.
- R9: `done_o` and `err_o` are single-cycle pulses and are never high together.
- R10: After reset, `done_o`, `err_o`, `rd_req_o`, `addr_o` and `level_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe; latches `instr_i` when idle |
| instr_i | input | 24 | Instruction word |
| index_i | input | 14 | Index register value |
| rd_req_o | output | 1 | Memory read request, one cycle |
| rd_addr_o | output | 14 | Memory read address |
| rd_data_i | input | 24 | Word returned by memory |
| rd_valid_i | input | 1 | Returned word is valid |
| addr_o | output | 14 | Effective address |
| done_o | output | 1 | Effective address ready, one cycle |
| err_o | output | 1 | Level limit reached, one cycle |
| level_o | output | 7 | Reads made in the current chain |

## Verification
With the bench's memory answering one cycle after each request, a chain of L levels is due 2+3L cycles after the start edge. An address with no indirection is due at 2 cycles, and a runaway chain at the default limit errors at cycle 194. Each directed task counts falling edges from the start pulse until `done_o` or `err_o` rises. It then compares that count, the address, the level and the number of read pulses it counted against values worked out in advance. On the next falling edge it confirms that the strobe has already dropped.

// File: rtl/iag_pkg.sv
// Package: shared widths, field positions and FSM state type for the
// indirect address generator. Assumes 24-bit words whose bit 0 is the MSB.
package iag_pkg;
    localparam int WORD_W = 24;
    localparam int ADDR_W = 14;
    // MSB-0 bit k sits at vector index WORD_W-1-k
    localparam int X_POS  = WORD_W - 1 - 1;
    localparam int I_POS  = WORD_W - 1 - 9;

    typedef struct packed {
        logic              idx;
        logic              ind;
        logic [ADDR_W-1:0] addr;
    } fields_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_INDEX = 3'd1,
        ST_FETCH = 3'd2,
        ST_WAIT  = 3'd3,
        ST_DONE  = 3'd4
    } state_t;
endpackage

// File: rtl/iag_decode.sv
// Module: field decoder. Pulls the index flag, indirect flag and address
// field out of a word; opcode and tag bits 0 and 2 are deliberately dropped.
module iag_decode
    import iag_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output fields_t           fields_o
);
    logic unused_fields;

    // Field extraction, purely combinational
    always_comb begin
        fields_o.idx  = word_i[X_POS];
        fields_o.ind  = word_i[I_POS];
        fields_o.addr = word_i[ADDR_W-1:0];
    end

    assign unused_fields = ^{word_i[WORD_W-1], word_i[X_POS-1:I_POS+1]};
endmodule

// File: rtl/iag_index_add.sv
// Module: index adder. Adds the index to the base when enabled; the sum
// wraps modulo 2^W and the carry is discarded.
module iag_index_add #(
    parameter int W = 14
) (
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] idx_i,
    input  logic         en_i,
    output logic [W-1:0] sum_o
);
    // Modular sum, carry dropped by width
    always_comb begin
        sum_o = base_i + (en_i ? idx_i : {W{1'b0}});
    end
endmodule

// File: rtl/iag_level_ctr.sv
// Module: level counter. Counts read requests in a chain, clears on a
// new operation and flags when the limit is reached. Assumes clr and inc
// are never asserted together.
module iag_level_ctr #(
    parameter int MAX_LEVELS = 64,
    parameter int LVL_W      = $clog2(MAX_LEVELS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [LVL_W-1:0] level_o,
    output logic             at_max_o
);
    localparam logic [LVL_W-1:0] LIMIT = LVL_W'(MAX_LEVELS);

    // Counter register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            level_o <= '0;
        end else if (inc_i) begin
            level_o <= level_o + 1'b1;
        end
    end

    assign at_max_o = (level_o == LIMIT);
endmodule

// File: rtl/ind_addr_gen.sv
// Module: indirect address generator (top). Indexes a word's address,
// then follows indirect references through the memory read port one
// level at a time until a word with no indirect flag is reached, or
// until MAX_LEVELS reads have been made (error). Assumes the memory
// answers each request with exactly one rd_valid_i pulse.
module ind_addr_gen
    import iag_pkg::*;
#(
    parameter int MAX_LEVELS = 64,
    parameter int LVL_W      = $clog2(MAX_LEVELS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] instr_i,
    input  logic [ADDR_W-1:0] index_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [WORD_W-1:0] rd_data_i,
    input  logic              rd_valid_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o,
    output logic              err_o,
    output logic [LVL_W-1:0]  level_o
);
    state_t            state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic [ADDR_W-1:0] ea_q;
    logic              err_q;
    fields_t           fld;
    logic [ADDR_W-1:0] ea_sum;
    logic              at_max;
    logic              lvl_clr, lvl_inc;

    iag_decode u_dec (
        .word_i   (word_q),
        .fields_o (fld)
    );

    iag_index_add #(.W(ADDR_W)) u_add (
        .base_i (fld.addr),
        .idx_i  (index_i),
        .en_i   (fld.idx),
        .sum_o  (ea_sum)
    );

    iag_level_ctr #(.MAX_LEVELS(MAX_LEVELS), .LVL_W(LVL_W)) u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (lvl_clr),
        .inc_i    (lvl_inc),
        .level_o  (level_o),
        .at_max_o (at_max)
    );

    // Next-state logic for the address chain walk
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_INDEX;
            ST_INDEX: state_d = (fld.ind && !at_max) ? ST_FETCH : ST_DONE;
            ST_FETCH: state_d = ST_WAIT;
            ST_WAIT:  if (rd_valid_i) state_d = ST_INDEX;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Current word: instruction on start, fetched word on read return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            word_q <= instr_i;
        end else if (state_q == ST_WAIT && rd_valid_i) begin
            word_q <= rd_data_i;
        end
    end

    // Effective address and error flag captured once per level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q  <= '0;
            err_q <= 1'b0;
        end else if (state_q == ST_INDEX) begin
            ea_q  <= ea_sum;
            err_q <= fld.ind && at_max;
        end
    end

    assign lvl_clr   = (state_q == ST_IDLE) && start_i;
    assign lvl_inc   = (state_q == ST_FETCH);
    assign rd_req_o  = (state_q == ST_FETCH);
    assign rd_addr_o = ea_q;
    assign addr_o    = ea_q;
    assign done_o    = (state_q == ST_DONE) && !err_q;
    assign err_o     = (state_q == ST_DONE) && err_q;
endmodule

// File: rtl/iag_checker.sv
// Module: protocol checker for ind_addr_gen, attached by bind. Watches
// ports only; assumes the synchronous active-low reset is held at start.
module iag_checker #(
    parameter int MAX_LEVELS = 64,
    parameter int LVL_W      = $clog2(MAX_LEVELS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req_o,
    input logic             done_o,
    input logic             err_o,
    input logic [LVL_W-1:0] level_o
);
    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9: done and error never together
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));
    // R4: one-cycle read request
    a_r4_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);
    // R6: each read request advances the level by one
    a_r6_level_step: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> (level_o == $past(level_o) + 1'b1));
    // R7: error only at the limit
    a_r7_err_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (level_o == LVL_W'(MAX_LEVELS)));
    // R3: completion issues no further read
    a_r3_no_read_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !rd_req_o);
endmodule

bind ind_addr_gen iag_checker #(.MAX_LEVELS(MAX_LEVELS), .LVL_W(LVL_W)) u_iag_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req_o (rd_req_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .level_o  (level_o)
);

// File: tb/test_ind_addr_gen.sv
// Bench: directed scenarios for ind_addr_gen with a one-cycle memory model.
module test_ind_addr_gen;
    localparam int CLK_PERIOD = 10;
    localparam int MAXL       = 64;
    localparam int LW         = $clog2(MAXL + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] instr_i = '0;
    logic [13:0] index_i = '0;
    logic        rd_req_o;
    logic [13:0] rd_addr_o;
    logic [23:0] rd_data_i;
    logic        rd_valid_i;
    logic [13:0] addr_o;
    logic        done_o, err_o;
    logic [LW-1:0] level_o;

    int checks = 0;
    int failures = 0;
    int reads = 0;
    int cycles = 0;
    logic [23:0] mem [int];

    ind_addr_gen #(.MAX_LEVELS(MAXL)) i_ind_addr_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .index_i(index_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_data_i(rd_data_i), .rd_valid_i(rd_valid_i), .addr_o(addr_o),
        .done_o(done_o), .err_o(err_o), .level_o(level_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: answers one cycle after each request
    always @(posedge clk) begin
        rd_valid_i <= rd_req_o;
        rd_data_i  <= mem.exists(int'(rd_addr_o)) ? mem[int'(rd_addr_o)] : 24'h0;
        if (rd_req_o) reads <= reads + 1;
        cycles <= cycles + 1;
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [23:0] mk(input logic x, input logic ind,
                                       input logic [5:0] op, input logic [13:0] a);
        logic [23:0] w;
        w = '0;
        w[22] = x;
        w[20:15] = op;
        w[14] = ind;
        w[13:0] = a;
        return w;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one chain and checks latency, address, level, reads and pulse
    task automatic run_chain(input string req, input logic [23:0] w,
                             input logic [13:0] idx, input int exp_addr,
                             input int exp_lvl, input int exp_err,
                             input int poke_at);
        int cyc = 0;
        int r0;
        @(negedge clk);
        r0 = reads;
        instr_i = w;
        index_i = idx;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        while (!(done_o || err_o) && cyc < 1000) begin
            if (poke_at != 0 && cyc == poke_at) begin
                instr_i = mk(1'b1, 1'b0, 6'h11, 14'h2AAA);
                start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            cyc = cyc + 1;
        end
        start_i = 1'b0;
        chk({req, " latency"}, cyc, 2 + 3 * exp_lvl);
        chk({req, " error flag"}, int'(err_o), exp_err);
        chk({req, " done flag"}, int'(done_o), 1 - exp_err);
        if (exp_err == 0) chk({req, " address"}, int'(addr_o), exp_addr);
        chk({req, " level"}, int'(level_o), exp_lvl);
        chk({req, " reads"}, reads - r0, exp_lvl);
        @(negedge clk);
        chk({req, " R9 pulse done"}, int'(done_o), 0);
        chk({req, " R9 pulse err"}, int'(err_o), 0);
    endtask

    task automatic t_reset;
        chk("R10 done", int'(done_o), 0);
        chk("R10 err", int'(err_o), 0);
        chk("R10 req", int'(rd_req_o), 0);
        chk("R10 addr", int'(addr_o), 0);
        chk("R10 level", int'(level_o), 0);
    endtask

    task automatic t_direct;
        run_chain("R1 R3 plain", mk(1'b0, 1'b0, 6'h2A, 14'h1234), 14'h0777, 'h1234, 0, 0, 0);
    endtask

    task automatic t_indexed;
        run_chain("R2 indexed", mk(1'b1, 1'b0, 6'h00, 14'h0100), 14'h0023, 'h0123, 0, 0, 0);
        run_chain("R2 wrap", mk(1'b1, 1'b0, 6'h00, 14'h3FF0), 14'h0020, 'h0010, 0, 0, 0);
    endtask

    task automatic t_one_level;
        logic [23:0] m;
        m = mk(1'b0, 1'b0, 6'h3F, 14'h0555);
        m[23] = 1'b1;
        m[21] = 1'b1;
        mem[32'h0200] = m;
        run_chain("R4 R5 one level", mk(1'b0, 1'b1, 6'h05, 14'h0200), 14'h0011, 'h0555, 1, 0, 0);
    endtask

    task automatic t_index_first;
        mem[32'h0305] = mk(1'b1, 1'b0, 6'h00, 14'h0010);
        run_chain("R2 R4 index before read", mk(1'b1, 1'b1, 6'h00, 14'h0300), 14'h0005, 'h0015, 1, 0, 0);
    endtask

    task automatic t_three_level;
        mem[32'h0400] = mk(1'b0, 1'b1, 6'h12, 14'h0410);
        mem[32'h0410] = mk(1'b1, 1'b1, 6'h34, 14'h0420);
        mem[32'h0425] = mk(1'b0, 1'b0, 6'h3F, 14'h0777);
        run_chain("R5 R6 three level", mk(1'b0, 1'b1, 6'h00, 14'h0400), 14'h0005, 'h0777, 3, 0, 0);
    endtask

    task automatic t_busy_start;
        run_chain("R8 start ignored", mk(1'b0, 1'b1, 6'h00, 14'h0400), 14'h0005, 'h0777, 3, 0, 3);
    endtask

    task automatic t_runaway;
        mem[32'h0600] = mk(1'b0, 1'b1, 6'h00, 14'h0600);
        run_chain("R7 runaway", mk(1'b0, 1'b1, 6'h00, 14'h0600), 14'h0000, 0, MAXL, 1, 0);
        run_chain("R6 recover after error", mk(1'b0, 1'b0, 6'h00, 14'h0042), 14'h0000, 'h0042, 0, 0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_direct();
        t_indexed();
        t_one_level();
        t_index_first();
        t_three_level();
        t_busy_start();
        t_runaway();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule